// File: doc/BRIEF.md
# Half-Warp Memory Access Coalescer

This block takes one memory request per thread from a group of sixteen threads and merges it into the smallest number of aligned memory transactions. A transaction covers 32, 64 or 128 bytes. Each request has a byte address, the shared element size and one bit in an active mask. The caller loads the set with a single start strobe. The block then emits a stream of records through a valid/ready handshake. Each record gives the aligned base address, a size code and the mask of threads it serves. A one-cycle done strobe follows the last record.

Each pass takes the lowest-numbered thread that is still pending. The element size picks the starting segment size, and the pass finds the aligned segment of that size that holds the lead thread's address. Every pending thread whose address lies in that segment joins the transaction. The segment is then halved as long as all the touched bytes stay within one half, stopping at 32 bytes. The served threads are retired, and passes continue until none are pending.

The FSM has four states. IDLE waits for start. SCAN computes one transaction. ISSUE presents it and holds it until it is accepted. DONE raises the completion strobe. The transitions are: IDLE to SCAN on start with a non-empty mask; IDLE to DONE on start with an empty mask; SCAN to ISSUE always; ISSUE to SCAN on acceptance with threads still pending; ISSUE to DONE on acceptance of the last transaction; DONE to IDLE always.

Top module: `hw_coalescer`

## Requirements
- R1: Each transaction is built around the lowest-numbered thread still pending, so records leave in order of their lead thread.
- R2: The starting segment size comes from the element size code `elem_size`: 0 (1 byte) gives 32 bytes, 1 (2 bytes) gives 64 bytes, 2 (4 bytes) and 3 (8 bytes) give 128 bytes.
- R3: A record's thread mask holds exactly the pending threads whose addresses fall in the lead thread's starting segment.
- R4: Before issue, a 128-byte segment becomes 64 bytes when the lowest and highest touched byte offsets share address bit 6. A 64-byte segment then becomes 32 bytes when they share bit 5. The kept half is the one holding the touched bytes.
- R5: `txn_size` encodes 0 = 32, 1 = 64, 2 = 128 bytes, and `txn_base` is aligned to that size.
- R6: Every active thread is served by exactly one record, and inactive threads never appear in a record mask.
- R7: While `txn_valid` is high and `txn_ready` is low, the record stays stable and valid.
- R8: `done` pulses for one cycle, in the cycle after the last record is accepted. With an empty active mask it pulses in the cycle after start, and no record is issued.
- R9: A start strobe that arrives while a set is being processed is ignored and does not alter the records being produced.
- R10: After reset, `txn_valid` and `done` are low.
- R11: Addresses are expected to be naturally aligned to the element size; each thread then touches bytes from its address up to its address plus size minus one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Loads addresses, mask and size when idle |
| active_mask | input | 16 | One bit per thread with a request |
| elem_size | input | 2 | Element size code (0:1B, 1:2B, 2:4B, 3:8B) |
| thread_addr | input | 512 | Sixteen 32-bit byte addresses, thread i at bits [32i+31:32i] |
| txn_valid | output | 1 | A transaction record is presented |
| txn_ready | input | 1 | Consumer accepts the record |
| txn_base | output | 32 | Aligned base address of the transaction |
| txn_size | output | 2 | Size code (0:32, 1:64, 2:128 bytes) |
| txn_mask | output | 16 | Threads served by this transaction |
| done | output | 1 | One-cycle completion strobe |

## Verification
A corrupted pending mask shows up at the ports within one transaction. A retired thread reappears in a later mask, a skipped thread never appears, or `done` arrives after too few or too many records. A wrong segment key or a wrong min/max offset shows in the very next record as a wrong mask, base or size. A stale record register under back-pressure changes the data that the consumer sees while `txn_valid` is held, so stalls are mixed into every sweep.

// File: rtl/coal_pkg.sv
package coal_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SCAN  = 2'd1,
        ST_ISSUE = 2'd2,
        ST_DONE  = 2'd3
    } coal_state_e;

    // size code: 0 = 32 B, 1 = 64 B, 2 = 128 B
    function automatic logic [1:0] start_code(input logic [1:0] esz);
        logic [1:0] c;
        unique case (esz)
            2'd0:    c = 2'd0;
            2'd1:    c = 2'd1;
            default: c = 2'd2;
        endcase
        return c;
    endfunction

    function automatic logic [6:0] span_minus1(input logic [1:0] esz);
        return 7'((1 << esz) - 1);
    endfunction

    function automatic logic [6:0] offset_mask(input logic [1:0] code);
        return 7'((32 << code) - 1);
    endfunction

endpackage

// File: rtl/coal_lowest.sv
module coal_lowest #(
    parameter int N  = 16,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  pend,
    output logic [IW-1:0] idx,
    output logic          any
);
    always_comb begin
        idx = '0;
        any = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend[i]) begin
                idx = IW'(i);
                any = 1'b1;
            end
        end
    end
endmodule

// File: rtl/coal_gather.sv
module coal_gather
    import coal_pkg::*;
#(
    parameter int N  = 16,
    parameter int AW = 32
) (
    input  logic [N*AW-1:0] addrs,
    input  logic [N-1:0]    pend,
    input  logic [AW-1:0]   lead_addr,
    input  logic [1:0]      init_code,
    input  logic [1:0]      esz,
    output logic [N-1:0]    hit,
    output logic [6:0]      min_off,
    output logic [6:0]      max_off
);
    logic [2:0]  seg_lsb;
    logic [AW-1:0] lead_key;
    logic [6:0]  lo_off [N];
    logic [6:0]  hi_off [N];

    assign seg_lsb  = 3'd5 + {1'b0, init_code};
    assign lead_key = lead_addr >> seg_lsb;

    for (genvar g = 0; g < N; g++) begin : g_thr
        logic [AW-1:0] a;
        assign a         = addrs[g*AW +: AW];
        assign hit[g]    = pend[g] && ((a >> seg_lsb) == lead_key);
        assign lo_off[g] = a[6:0];
        assign hi_off[g] = a[6:0] + span_minus1(esz);
    end

    always_comb begin
        min_off = 7'h7f;
        max_off = 7'h00;
        for (int i = 0; i < N; i++) begin
            if (hit[i]) begin
                if (lo_off[i] < min_off) min_off = lo_off[i];
                if (hi_off[i] > max_off) max_off = hi_off[i];
            end
        end
    end
endmodule

// File: rtl/coal_shrink.sv
module coal_shrink
    import coal_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [AW-8:0] blk_hi,
    input  logic [1:0]    init_code,
    input  logic [6:0]    min_off,
    input  logic [6:0]    max_off,
    output logic [AW-1:0] base,
    output logic [1:0]    code
);
    logic [1:0] c1;

    always_comb begin
        c1 = init_code;
        if (c1 == 2'd2 && (min_off[6] == max_off[6])) c1 = 2'd1;
        if (c1 == 2'd1 && (min_off[5] == max_off[5])) c1 = 2'd0;
        code = c1;
        base = {blk_hi, min_off & ~offset_mask(c1)};
    end

    always_comb begin
        assert (code <= init_code);
    end
endmodule

// File: rtl/hw_coalescer.sv
module hw_coalescer
    import coal_pkg::*;
#(
    parameter int N  = 16,
    parameter int AW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [N-1:0]    active_mask,
    input  logic [1:0]      elem_size,
    input  logic [N*AW-1:0] thread_addr,
    output logic            txn_valid,
    input  logic            txn_ready,
    output logic [AW-1:0]   txn_base,
    output logic [1:0]      txn_size,
    output logic [N-1:0]    txn_mask,
    output logic            done
);
    localparam int IW = $clog2(N);

    coal_state_e st, st_nx;

    logic [N*AW-1:0] addr_q;
    logic [N-1:0]    pend_q;
    logic [1:0]      esz_q;
    logic [AW-1:0]   base_q;
    logic [1:0]      size_q;
    logic [N-1:0]    mask_q;

    logic [IW-1:0]   lead_idx;
    logic            lead_any;
    logic [AW-1:0]   lead_addr;
    logic [1:0]      init_code;
    logic [N-1:0]    hit;
    logic [6:0]      min_off, max_off;
    logic [AW-1:0]   new_base;
    logic [1:0]      new_code;
    logic [N-1:0]    pend_left;

    coal_lowest #(.N(N), .IW(IW)) u_lowest (
        .pend (pend_q),
        .idx  (lead_idx),
        .any  (lead_any)
    );

    assign lead_addr = addr_q[lead_idx*AW +: AW];
    assign init_code = start_code(esz_q);

    coal_gather #(.N(N), .AW(AW)) u_gather (
        .addrs     (addr_q),
        .pend      (pend_q),
        .lead_addr (lead_addr),
        .init_code (init_code),
        .esz       (esz_q),
        .hit       (hit),
        .min_off   (min_off),
        .max_off   (max_off)
    );

    coal_shrink #(.AW(AW)) u_shrink (
        .blk_hi    (lead_addr[AW-1:7]),
        .init_code (init_code),
        .min_off   (min_off),
        .max_off   (max_off),
        .base      (new_base),
        .code      (new_code)
    );

    assign pend_left = pend_q & ~mask_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // transitions
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:  if (start) st_nx = (active_mask == '0) ? ST_DONE : ST_SCAN;
            ST_SCAN:  st_nx = ST_ISSUE;
            ST_ISSUE: if (txn_ready) st_nx = (pend_left == '0) ? ST_DONE : ST_SCAN;
            ST_DONE:  st_nx = ST_IDLE;
        endcase
    end

    // data path
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            pend_q <= '0;
            esz_q  <= '0;
            base_q <= '0;
            size_q <= '0;
            mask_q <= '0;
        end else begin
            unique case (st)
                ST_IDLE: if (start) begin
                    addr_q <= thread_addr;
                    pend_q <= active_mask;
                    esz_q  <= elem_size;
                end
                ST_SCAN: begin
                    base_q <= new_base;
                    size_q <= new_code;
                    mask_q <= hit;
                end
                ST_ISSUE: if (txn_ready) pend_q <= pend_left;
                ST_DONE: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        txn_valid = (st == ST_ISSUE);
        done      = (st == ST_DONE);
        txn_base  = base_q;
        txn_size  = size_q;
        txn_mask  = mask_q;
    end

    AST_LEAD_EXISTS: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SCAN) |-> lead_any) else $error("scan with nothing pending"); // R1
    AST_RECORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && !txn_ready) |=> (txn_valid && $stable(txn_base) && $stable(txn_size) && $stable(txn_mask))); // R7
    AST_BASE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid |-> ((txn_base[6:0] & offset_mask(txn_size)) == 7'd0)); // R5
    AST_SIZE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid |-> (txn_size != 2'd3)); // R5
    AST_SERVE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid |-> ((txn_mask != '0) && ((txn_mask & ~pend_q) == '0))); // R6
    AST_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && txn_ready) |=> ((pend_q & $past(txn_mask)) == '0)); // R6
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !txn_valid); // R8
endmodule

// File: tb/hw_coalescer_bench.sv
`timescale 1ns/1ps
module hw_coalescer_bench;
    localparam int N  = 16;
    localparam int AW = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [N-1:0]    active_mask = '0;
    logic [1:0]      elem_size = '0;
    logic [N*AW-1:0] thread_addr = '0;
    logic            txn_valid;
    logic            txn_ready = 1'b0;
    logic [AW-1:0]   txn_base;
    logic [1:0]      txn_size;
    logic [N-1:0]    txn_mask;
    logic            done;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic [AW-1:0] ad [N];
    logic [AW-1:0] e_base [N];
    logic [1:0]    e_size [N];
    logic [N-1:0]  e_mask [N];
    int            n_exp;

    always #2.5 clk = ~clk;

    hw_coalescer #(.N(N), .AW(AW)) u_hw_coalescer (
        .clk, .rst_n, .start, .active_mask, .elem_size, .thread_addr,
        .txn_valid, .txn_ready, .txn_base, .txn_size, .txn_mask, .done
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // reference model built from R1..R5, R11
    task automatic build_expect(input logic [N-1:0] m, input logic [1:0] esz);
        logic [N-1:0] pend = m;
        n_exp = 0;
        while (pend != '0) begin
            int lead = 0;
            int lsb;
            logic [N-1:0] hm = '0;
            int mn = 127, mx = 0;
            int code;
            for (int i = N - 1; i >= 0; i--) if (pend[i]) lead = i;
            code = (esz == 0) ? 0 : (esz == 1) ? 1 : 2;        // R2
            lsb = 5 + code;
            for (int i = 0; i < N; i++) begin
                if (pend[i] && ((ad[i] >> lsb) == (ad[lead] >> lsb))) begin   // R3
                    int lo = int'(ad[i] & 32'h7f);
                    int hi = lo + (1 << esz) - 1;                             // R11
                    hm[i] = 1'b1;
                    if (lo < mn) mn = lo;
                    if (hi > mx) mx = hi;
                end
            end
            if (code == 2 && ((mn >> 6) == (mx >> 6))) code = 1;              // R4
            if (code == 1 && (((mn >> 5) & 1) == ((mx >> 5) & 1))) code = 0;
            e_base[n_exp] = (ad[lead] & ~32'h7f) | (AW'(mn) & ~AW'((32 << code) - 1) & 32'h7f);
            e_size[n_exp] = 2'(code);
            e_mask[n_exp] = hm;
            n_exp = n_exp + 1;
            pend = pend & ~hm;
        end
    endtask

    task automatic run_case(input logic [N-1:0] m, input logic [1:0] esz, input int stall, input bit poke);
        int got = 0;
        logic [N-1:0] seen = '0;
        bit fin = 0;
        build_expect(m, esz);
        @(negedge clk);
        for (int i = 0; i < N; i++) thread_addr[i*AW +: AW] = ad[i];
        active_mask = m;
        elem_size = esz;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int t = 0; t < 400 && !fin; t++) begin
            if (poke && t == 2) begin        // R9: start while busy
                start = 1'b1;
                active_mask = '1;
                thread_addr = {N{32'h0000_1000}};
                elem_size = 2'd0;
            end else begin
                start = 1'b0;
            end
            case (stall)
                0: txn_ready = 1'b1;
                1: txn_ready = t[0];
                default: txn_ready = 1'($urandom_range(0, 1));
            endcase
            if (done) begin
                check(got == n_exp, "R8 record count at done", 64'(got), 64'(n_exp));
                check(seen == m, "R6 threads served", 64'(seen), 64'(m));
                fin = 1;
            end else if (txn_valid && txn_ready) begin
                if (got >= n_exp) begin
                    check(0, "R6 extra record", 64'(got), 64'(n_exp));
                end else begin
                    check(txn_mask == e_mask[got], "R3 mask", 64'(txn_mask), 64'(e_mask[got]));
                    check(txn_base == e_base[got], "R1 R4 base", 64'(txn_base), 64'(e_base[got]));
                    check(txn_size == e_size[got], "R2 R5 size", 64'(txn_size), 64'(e_size[got]));
                    check((seen & txn_mask) == '0, "R6 no repeat", 64'(seen & txn_mask), 64'(0));
                end
                seen = seen | txn_mask;
                got = got + 1;
            end
            if (!fin) @(negedge clk);
        end
        check(fin, "R8 done seen", 64'(fin), 64'(1));
        start = 1'b0;
        txn_ready = 1'b0;
        @(negedge clk);
        check(!done && !txn_valid, "R8 single pulse", 64'({done, txn_valid}), 64'(0));
    endtask

    initial begin
        #1;
        check(!txn_valid && !done, "R10 reset outputs", 64'({txn_valid, done}), 64'(0));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!txn_valid && !done, "R10 idle after reset", 64'({txn_valid, done}), 64'(0));

        // R8: empty mask
        for (int i = 0; i < N; i++) ad[i] = 32'h100 + 32'(4 * i);
        run_case('0, 2'd2, 0, 0);

        // strides over words for every element size and stall mode
        for (int esz = 0; esz < 4; esz++)
            for (int stride = 1; stride <= 8; stride = stride * 2)
                for (int st = 0; st < 3; st++) begin
                    for (int i = 0; i < N; i++) ad[i] = 32'h0004_0000 + 32'(i * stride * (1 << esz));
                    run_case('1, 2'(esz), st, 0);
                end

        // broadcast and reversed order
        for (int i = 0; i < N; i++) ad[i] = 32'h0000_2040;
        run_case('1, 2'd2, 1, 0);
        for (int i = 0; i < N; i++) ad[i] = 32'h0000_3000 + 32'(4 * (N - 1 - i));
        run_case(16'hA5C3, 2'd2, 2, 0);

        // R9: start during processing
        for (int i = 0; i < N; i++) ad[i] = 32'h0000_5000 + 32'(64 * i);
        run_case('1, 2'd2, 1, 1);

        // random sweep
        for (int k = 0; k < 300; k++) begin
            logic [1:0] esz = 2'($urandom_range(0, 3));
            logic [AW-1:0] bs = $urandom() & ~32'hff;
            for (int i = 0; i < N; i++)
                ad[i] = bs + (32'($urandom_range(0, 511)) & ~32'((1 << esz) - 1));
            run_case(16'($urandom()), esz, k % 3, (k % 17) == 0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule